// File: doc/BRIEF.md
# Dual-Read Register File with Hardwired Zero Entry

This block is the general-purpose register storage of a simple integer datapath. It holds a set of equal-width registers. It provides two independent read ports, which any instruction uses to fetch both source operands in the same cycle. It has one write port that stores a result.

Reads are purely combinational: each read port returns the selected entry with no clock in between. Writes commit on the falling clock edge. A result driven onto the write port early in a cycle is therefore already visible on the read ports during the second half of that cycle, so a following operand fetch sees it without a bypass path.

Entry 0 is a constant zero source. It always reads as zero, and any write aimed at it is dropped. An active-high synchronous reset, sampled on the falling clock edge, clears every stored entry.

Top module: `dual_read_regfile`

## Requirements
- R1: While `rst` is high at a falling clock edge, every entry is cleared. After reset, both read ports return 0 for every address.
- R2: When `wr_en` is high at a falling clock edge and `wr_addr` is not 0, entry `wr_addr` takes the value on `wr_data`.
- R3: When `wr_en` is low at a falling clock edge, no entry changes.
- R4: Address 0 always reads as 0 on both ports, even right after a write with `wr_addr` = 0 and nonzero data.
- R5: A value written at a falling edge is returned by a read of that address before the next rising edge, in the same clock cycle.
- R6: The two read ports are independent. Each port returns the entry selected by its own address, even when the addresses differ.
- R7: When both read addresses are equal, both ports return identical data.
- R8: A write changes only the addressed entry. All other entries keep their values.
- R9: A write does not take effect at the rising edge. Between the rising edge and the falling edge, a read of the target address still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage updates on its falling edge |
| rst | input | 1 | Active-high synchronous reset, sampled at the falling edge |
| rd_addr_a | input | 5 | Read address, port A |
| rd_addr_b | input | 5 | Read address, port B |
| rd_data_a | output | 32 | Combinational read data, port A |
| rd_data_b | output | 32 | Combinational read data, port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |

## Verification
The bench builds the block with its default parameters: 32 entries of 32 bits. With this setting every address, including the top entry 31 and the zero entry, can be written and read back in a short run. Full-width patterns such as all-ones and alternating bits reach every data bit. Writes and reads are issued in the same cycle so that the falling-edge visibility is exercised. An extra probe taken before the falling edge confirms that nothing commits at the rising edge. A reset issued in the middle of the run, over populated contents, shows that the clear reaches every entry.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int unsigned RF_DEPTH_DEF = 32;
    localparam int unsigned RF_WIDTH_DEF = 32;
    localparam int unsigned RF_RD_PORTS  = 2;

    typedef enum logic [1:0] {
        WR_IDLE  = 2'b00,
        WR_DROP  = 2'b01,
        WR_STORE = 2'b10
    } wr_kind_e;

    // Classifies a write request: stored, discarded (entry zero) or none.
    function automatic wr_kind_e classify_write(input logic en, input logic addr_is_zero);
        if (!en)
            return WR_IDLE;
        else if (addr_is_zero)
            return WR_DROP;
        else
            return WR_STORE;
    endfunction

endpackage

// File: rtl/regfile_wr_decode.sv
module regfile_wr_decode
    import regfile_pkg::*;
#(
    parameter int unsigned DEPTH = RF_DEPTH_DEF,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    output logic [DEPTH-1:0]  wr_sel
);

    wr_kind_e kind;

    always_comb begin
        kind = classify_write(wr_en, (wr_addr == '0));
    end

    // Entry zero never gets a select line.
    assign wr_sel[0] = 1'b0;

    for (genvar i = 1; i < DEPTH; i++) begin : g_sel
        assign wr_sel[i] = (kind == WR_STORE) && (wr_addr == AW'(i));
    end

    // R3: a disabled write selects nothing
    always_comb begin
        if (!wr_en) begin
            p_no_sel_when_idle_r3: assert (wr_sel == '0);
        end
    end

endmodule

// File: rtl/regfile_bank.sv
module regfile_bank
    import regfile_pkg::*;
#(
    parameter int unsigned DEPTH = RF_DEPTH_DEF,
    parameter int unsigned WIDTH = RF_WIDTH_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [DEPTH-1:0]            wr_sel,
    input  logic [WIDTH-1:0]            wr_data,
    output logic [DEPTH-1:0][WIDTH-1:0] entries
);

    // Entry zero is a constant source, not a storage element.
    assign entries[0] = '0;

    for (genvar i = 1; i < DEPTH; i++) begin : g_entry
        always_ff @(negedge clk) begin
            if (rst)
                entries[i] <= '0;
            else if (wr_sel[i])
                entries[i] <= wr_data;
        end

        // R2: a selected entry holds the written data after the edge
        p_entry_load_r2: assert property (@(negedge clk) disable iff (rst)
            wr_sel[i] |=> entries[i] == $past(wr_data));

        // R8: an unselected entry keeps its value
        p_entry_keep_r8: assert property (@(negedge clk) disable iff (rst)
            !wr_sel[i] |=> $stable(entries[i]));
    end

    // R1: reset clears the whole bank
    p_reset_clear_r1: assert property (@(negedge clk)
        rst |=> entries == '0);

endmodule

// File: rtl/regfile_rd_port.sv
module regfile_rd_port
    import regfile_pkg::*;
#(
    parameter int unsigned DEPTH = RF_DEPTH_DEF,
    parameter int unsigned WIDTH = RF_WIDTH_DEF,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][WIDTH-1:0] entries,
    input  logic [AW-1:0]               rd_addr,
    output logic [WIDTH-1:0]            rd_data
);

    always_comb begin
        rd_data = entries[rd_addr];
    end

endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile
    import regfile_pkg::*;
#(
    parameter int unsigned DEPTH = RF_DEPTH_DEF,
    parameter int unsigned WIDTH = RF_WIDTH_DEF,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_addr_a,
    input  logic [AW-1:0]    rd_addr_b,
    output logic [WIDTH-1:0] rd_data_a,
    output logic [WIDTH-1:0] rd_data_b,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);

    logic [DEPTH-1:0]                     sel;
    logic [DEPTH-1:0][WIDTH-1:0]          entries;
    logic [RF_RD_PORTS-1:0][AW-1:0]       rd_addr;
    logic [RF_RD_PORTS-1:0][WIDTH-1:0]    rd_data;

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;
    assign rd_data_a  = rd_data[0];
    assign rd_data_b  = rd_data[1];

    regfile_wr_decode #(.DEPTH(DEPTH)) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_sel  (sel)
    );

    regfile_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (sel),
        .wr_data (wr_data),
        .entries (entries)
    );

    for (genvar p = 0; p < RF_RD_PORTS; p++) begin : g_rd
        regfile_rd_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_port (
            .entries (entries),
            .rd_addr (rd_addr[p]),
            .rd_data (rd_data[p])
        );
    end

    // R4: address zero reads zero on either port
    p_zero_read_a_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == '0) |-> (rd_data_a == '0));
    p_zero_read_b_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    // R7: equal addresses give equal data
    p_same_addr_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

    // R3: nothing moves when writes are disabled
    p_idle_stable_r3: assert property (@(negedge clk) disable iff (rst)
        !wr_en |=> $stable(entries));

endmodule

// File: tb/dual_read_regfile_bench.sv
module dual_read_regfile_bench;

    localparam int DEPTH = 32;
    localparam int WIDTH = 32;
    localparam int AW    = 5;

    logic             clk = 1'b0;
    logic             rst;
    logic [AW-1:0]    rd_addr_a, rd_addr_b, wr_addr;
    logic [WIDTH-1:0] rd_data_a, rd_data_b, wr_data;
    logic             wr_en;

    int tests  = 0;
    int fails  = 0;
    logic [WIDTH-1:0] model [DEPTH];

    logic [WIDTH-1:0] q_exp_a [$];
    logic [WIDTH-1:0] q_exp_b [$];
    string            q_tag   [$];

    always #5 clk = ~clk;

    dual_read_regfile u_dual_read_regfile (
        .clk       (clk),
        .rst       (rst),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    task automatic check(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; the expected read results go to the scoreboard.
    task automatic cyc(input logic we, input logic [AW-1:0] wa, input logic [WIDTH-1:0] wd,
                       input logic [AW-1:0] ra, input logic [AW-1:0] rb, input string tag,
                       input bit early = 0);
        logic [WIDTH-1:0] old_a;
        @(posedge clk);
        #1;
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_addr_a = ra; rd_addr_b = rb;
        old_a = model[ra];
        if (we && wa != 0) model[wa] = wd;
        q_exp_a.push_back(model[ra]);
        q_exp_b.push_back(model[rb]);
        q_tag.push_back(tag);
        if (early) begin
            #2;
            check("R9 pre-fall", rd_data_a, old_a);
        end
    endtask

    task automatic do_reset(int n);
        @(posedge clk);
        #1;
        rst = 1'b1; wr_en = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (n) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    // Monitor: compares after the falling edge, before the next rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q_tag.size() != 0) begin
                string t;
                logic [WIDTH-1:0] ea, eb;
                t  = q_tag.pop_front();
                ea = q_exp_a.pop_front();
                eb = q_exp_b.pop_front();
                check({t, " portA"}, rd_data_a, ea);
                check({t, " portB"}, rd_data_b, eb);
            end
        end
    end

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr_a = '0; rd_addr_b = '0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        do_reset(3);

        // R1: every entry reads zero after reset
        for (int i = 0; i < DEPTH; i += 2) cyc(0, 0, 0, AW'(i), AW'(i + 1), "R1");

        // R2 / R5: write and read the same entry in one cycle
        cyc(1, 5, 32'hDEADBEEF, 5, 0, "R5");
        cyc(1, 31, 32'hFFFFFFFF, 31, 5, "R2");
        cyc(1, 1, 32'hA5A5A5A5, 1, 31, "R2");
        cyc(1, 17, 32'h5A5A5A5A, 17, 1, "R5");

        // R9: before the falling edge the old value is still seen
        cyc(1, 5, 32'h12345678, 5, 17, "R9", 1);

        // R3: writes disabled leave contents alone
        cyc(0, 5, 32'h0BADF00D, 5, 31, "R3");
        cyc(0, 1, 32'h00000000, 1, 17, "R3");

        // R4: writing entry zero is dropped
        cyc(1, 0, 32'hCAFEF00D, 0, 0, "R4");
        cyc(0, 0, 0, 0, 5, "R4");

        // R6: different addresses, independent data
        cyc(0, 0, 0, 31, 1, "R6");
        cyc(0, 0, 0, 17, 5, "R6");

        // R7: same address on both ports
        cyc(0, 0, 0, 17, 17, "R7");
        cyc(1, 9, 32'h0F0F0F0F, 9, 9, "R7");

        // R8: fill all entries, then rewrite one and check the rest
        for (int i = 1; i < DEPTH; i++) cyc(1, AW'(i), WIDTH'(i) * 32'h01010101, AW'(i), AW'(i - 1), "R2");
        cyc(1, 16, 32'h80000001, 15, 17, "R8");
        for (int i = 0; i < DEPTH; i += 2) cyc(0, 0, 0, AW'(i), AW'(i + 1), "R8");

        // R1: reset over populated contents
        @(negedge clk); #3;
        do_reset(2);
        for (int i = 0; i < DEPTH; i += 2) cyc(0, 0, 0, AW'(i), AW'(i + 1), "R1");

        repeat (3) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule